// File: doc/BRIEF.md
# Interrupt Source Sense and Pending Front End

This block sits at the input side of a wired-interrupt controller with `NUM_SRC` sources, numbered 1 to `NUM_SRC`. Source 0 does not exist. Every external request line passes through a synchronizer. A per-source sense mode then turns the line into a pending bit. The mode can ignore the line, use it only from software, catch a rising or falling transition, or follow a high or low level. The block also keeps a per-source enable bit. It presents the AND of pending and enable as a vector to the delivery and arbitration logic. When that logic claims a source, it can clear the source's pending bit through a separate request.

Software reaches the block through a simple 32-bit bus that uses word addresses (byte offset divided by 4). There is one configuration word per source. Set and clear bit arrays cover 32 sources per word. Four registers set or clear pending or enable for a single source, taking the source number as the write data. Reads are combinational.

Top module: `irq_src_frontend`

## Requirements
- R1: After reset, every pending bit, enable bit and sense mode is 0, and `irq_o` is all zeros.
- R2: The configuration word of source s is at word address s (byte 0x004+4*(s-1)). Bits 2:0 hold the mode: 0 off, 1 detached, 4 rising, 5 falling, 6 high, 7 low. Writing code 2 or 3 stores 0. Reading returns the mode in bits 2:0 and 0 in every other bit, including the delegate flag in bit 10.
- R3: In rising mode, a 0-to-1 transition of the synchronized input sets pending three clock edges after the input changes. Pending stays set after the input falls.
- R4: In falling mode, a 1-to-0 transition sets pending with the same latency, and a rising transition does not.
- R5: In high mode, pending equals the synchronized input; in low mode it equals its inverse. Software set and clear of pending have no effect in these modes.
- R6: In off mode, pending and enable are 0. Writing off clears the enable, and set writes to pending or enable have no effect.
- R7: In detached mode the input line has no effect on pending, while software set and clear still act.
- R8: Writing source number n sets or clears one bit, depending on the byte address: 0x1CDC sets pending, 0x1DDC clears pending, 0x1EDC sets enable, 0x1FDC clears enable. A value of 0 or above `NUM_SRC` changes nothing.
- R9: The bit arrays start at byte addresses 0x1C00 (set pending), 0x1D00 (clear pending), 0x1E00 (set enable) and 0x1F00 (clear enable). Bit j of word k acts on source 32k+j. Reading the 0x1C00 array returns the pending bits, reading the 0x1E00 array returns the enable bits, and reading the clear arrays returns 0.
- R10: Any write to a source's configuration word clears that source's pending bit on the same edge. A transition that is seen in that cycle is lost.
- R11: A claim request with a source number clears that source's pending bit in edge or detached mode. The request is ignored in level modes.
- R12: `irq_o[s]` is pending AND enable for source s, and `irq_o[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_SRC | External request lines, bit s for source s |
| bus_we | input | 1 | Write strobe |
| bus_waddr | input | ADDR_W | Write word address |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | ADDR_W | Read word address |
| bus_rdata | output | 32 | Read data (combinational) |
| claim_valid | input | 1 | Claim-clear request |
| claim_id | input | IDW | Source number to clear |
| irq_o | output | NUM_SRC+1 | Pending and enabled vector, bit 0 unused |

## Verification
The bench uses 40 sources, so the bit arrays span two words. This exposes any wrong word or bit mapping, and a design that mapped bit j to source j+1 would fail the array readbacks.

It sweeps the by-number registers across every source and also writes numbers 0 and 41. A design with an off-by-one range test would set a stray bit or miss the last source.

The sense modes are exercised at their edges:
- A sticky edge latch that follows the level would drop pending when the input falls.
- Level modes that accept software writes or claims would change pending against the input.
- An off mode that still accepts writes would raise `irq_o`.
- Missing clear-on-configure would leave pending set after a mode write.

// File: rtl/srcfe_pkg.sv
package srcfe_pkg;

   typedef enum logic [2:0] {
      SM_OFF    = 3'd0,
      SM_DETACH = 3'd1,
      SM_RISE   = 3'd4,
      SM_FALL   = 3'd5,
      SM_HIGH   = 3'd6,
      SM_LOW    = 3'd7
   } sense_e;

   // Word addresses (byte offset / 4)
   localparam int W_IP_SET_ARR = 'h700;
   localparam int W_IP_CLR_ARR = 'h740;
   localparam int W_IE_SET_ARR = 'h780;
   localparam int W_IE_CLR_ARR = 'h7C0;
   localparam int W_IP_SET_NUM = 'h737;
   localparam int W_IP_CLR_NUM = 'h777;
   localparam int W_IE_SET_NUM = 'h7B7;
   localparam int W_IE_CLR_NUM = 'h7F7;

   // Reserved codes fall back to off
   function automatic sense_e to_sense(input logic [2:0] code);
      case (code)
         3'd1:    return SM_DETACH;
         3'd4:    return SM_RISE;
         3'd5:    return SM_FALL;
         3'd6:    return SM_HIGH;
         3'd7:    return SM_LOW;
         default: return SM_OFF;
      endcase
   endfunction

endpackage

// File: rtl/srcfe_sync.sv
module srcfe_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/srcfe_decode.sv
module srcfe_decode
   import srcfe_pkg::*;
#(
   parameter int NUM_SRC = 31,
   parameter int ADDR_W  = 12,
   parameter int IDW     = 5
) (
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [31:0]       wdata,
   input  logic              claim_valid,
   input  logic [IDW-1:0]    claim_id,
   output logic [NUM_SRC:1]  cfg_we,
   output logic [NUM_SRC:1]  ip_set,
   output logic [NUM_SRC:1]  ip_clr,
   output logic [NUM_SRC:1]  ie_set,
   output logic [NUM_SRC:1]  ie_clr,
   output logic [NUM_SRC:1]  claim_clr
);
   for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
      localparam int K = s / 32;
      localparam int B = s % 32;
      logic num_hit;
      assign num_hit = (wdata == 32'(s));

      assign cfg_we[s] = we && (waddr == ADDR_W'(s));
      assign ip_set[s] = we && ((waddr == ADDR_W'(W_IP_SET_ARR + K) && wdata[B]) ||
                                (waddr == ADDR_W'(W_IP_SET_NUM) && num_hit));
      assign ip_clr[s] = we && ((waddr == ADDR_W'(W_IP_CLR_ARR + K) && wdata[B]) ||
                                (waddr == ADDR_W'(W_IP_CLR_NUM) && num_hit));
      assign ie_set[s] = we && ((waddr == ADDR_W'(W_IE_SET_ARR + K) && wdata[B]) ||
                                (waddr == ADDR_W'(W_IE_SET_NUM) && num_hit));
      assign ie_clr[s] = we && ((waddr == ADDR_W'(W_IE_CLR_ARR + K) && wdata[B]) ||
                                (waddr == ADDR_W'(W_IE_CLR_NUM) && num_hit));
      assign claim_clr[s] = claim_valid && (claim_id == IDW'(s));
   end
endmodule

// File: rtl/srcfe_slot.sv
module srcfe_slot
   import srcfe_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   cfg_we,
   input  sense_e cfg_mode,
   input  logic   lvl_in,
   input  logic   ip_set,
   input  logic   ip_clr,
   input  logic   ie_set,
   input  logic   ie_clr,
   input  logic   claim_clr,
   output sense_e mode_o,
   output logic   pend_o,
   output logic   en_o
);
   sense_e mode_q;
   logic   prev_q, pend_q, en_q;
   logic   pend_d, en_d, edge_hit;

   assign edge_hit = (mode_q == SM_RISE &&  lvl_in && !prev_q) ||
                     (mode_q == SM_FALL && !lvl_in &&  prev_q);

   always_comb begin
      case (mode_q)
         SM_DETACH:        pend_d = (pend_q && !(ip_clr || claim_clr)) || ip_set;
         SM_RISE, SM_FALL: pend_d = (pend_q && !(ip_clr || claim_clr)) || ip_set || edge_hit;
         SM_HIGH:          pend_d = lvl_in;
         SM_LOW:           pend_d = !lvl_in;
         default:          pend_d = 1'b0;
      endcase
      if (cfg_we) pend_d = 1'b0;

      if (mode_q == SM_OFF || (cfg_we && cfg_mode == SM_OFF)) en_d = 1'b0;
      else                                                    en_d = (en_q && !ie_clr) || ie_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= SM_OFF;
         prev_q <= 1'b0;
         pend_q <= 1'b0;
         en_q   <= 1'b0;
      end else begin
         if (cfg_we) mode_q <= cfg_mode;
         prev_q <= lvl_in;
         pend_q <= pend_d;
         en_q   <= en_d;
      end
   end

   assign mode_o = mode_q;
   assign pend_o = pend_q;
   assign en_o   = en_q;

   a_r6_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q == SM_OFF |-> !pend_q && !en_q);
   a_r10_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> !pend_q);
   a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == SM_RISE && lvl_in && !prev_q && !cfg_we) |=> pend_q);
   a_r4_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == SM_FALL && !lvl_in && prev_q && !cfg_we) |=> pend_q);
   a_r5_high_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == SM_HIGH && !cfg_we) |=> pend_q == $past(lvl_in));
   a_r7_detach_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == SM_DETACH && !cfg_we && !ip_set && !ip_clr && !claim_clr) |=> $stable(pend_q));
endmodule

// File: rtl/irq_src_frontend.sv
module irq_src_frontend
   import srcfe_pkg::*;
#(
   parameter int NUM_SRC     = 31,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 12,
   parameter int IDW         = $clog2(NUM_SRC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_SRC:1]  irq_in,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_waddr,
   input  logic [31:0]       bus_wdata,
   input  logic [ADDR_W-1:0] bus_raddr,
   output logic [31:0]       bus_rdata,
   input  logic              claim_valid,
   input  logic [IDW-1:0]    claim_id,
   output logic [NUM_SRC:0]  irq_o
);
   localparam int NUM_WORDS = (NUM_SRC + 1 + 31) / 32;

   if (NUM_SRC < 1 || NUM_SRC > 1023) begin : g_bad_num
      $error("NUM_SRC must lie in 1..1023");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 11) begin : g_bad_addr
      $error("ADDR_W must be at least 11");
   end
   if (IDW < $clog2(NUM_SRC + 1)) begin : g_bad_idw
      $error("IDW too narrow for NUM_SRC");
   end

   logic [NUM_SRC:1] lvl;
   logic [NUM_SRC:1] cfg_we, ip_set, ip_clr, ie_set, ie_clr, claim_clr;
   logic [NUM_SRC:1] pend, en;
   sense_e           mode_q [1:NUM_SRC];
   sense_e           cfg_mode;
   logic [NUM_WORDS*32-1:0] pend_flat, en_flat;

   assign cfg_mode = to_sense(bus_wdata[2:0]);

   srcfe_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_in), .q(lvl)
   );

   srcfe_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .IDW(IDW)) u_dec (
      .we(bus_we), .waddr(bus_waddr), .wdata(bus_wdata),
      .claim_valid(claim_valid), .claim_id(claim_id),
      .cfg_we(cfg_we), .ip_set(ip_set), .ip_clr(ip_clr),
      .ie_set(ie_set), .ie_clr(ie_clr), .claim_clr(claim_clr)
   );

   for (genvar s = 1; s <= NUM_SRC; s++) begin : g_slot
      srcfe_slot u_slot (
         .clk(clk), .rst_n(rst_n),
         .cfg_we(cfg_we[s]), .cfg_mode(cfg_mode), .lvl_in(lvl[s]),
         .ip_set(ip_set[s]), .ip_clr(ip_clr[s]),
         .ie_set(ie_set[s]), .ie_clr(ie_clr[s]), .claim_clr(claim_clr[s]),
         .mode_o(mode_q[s]), .pend_o(pend[s]), .en_o(en[s])
      );
      assign irq_o[s] = pend[s] & en[s];
   end
   assign irq_o[0] = 1'b0;

   always_comb begin
      pend_flat = '0;
      en_flat   = '0;
      for (int s = 1; s <= NUM_SRC; s++) begin
         pend_flat[s] = pend[s];
         en_flat[s]   = en[s];
      end
      bus_rdata = '0;
      for (int s = 1; s <= NUM_SRC; s++)
         if (bus_raddr == ADDR_W'(s)) bus_rdata = {29'd0, mode_q[s]};
      for (int k = 0; k < NUM_WORDS; k++) begin
         if (bus_raddr == ADDR_W'(W_IP_SET_ARR + k)) bus_rdata = pend_flat[k*32 +: 32];
         if (bus_raddr == ADDR_W'(W_IE_SET_ARR + k)) bus_rdata = en_flat[k*32 +: 32];
      end
   end

   a_r11_level_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_valid && claim_id == IDW'(1) && mode_q[1] == SM_HIGH && lvl[1] && !cfg_we[1])
      |=> pend[1]);
   a_r12_masked_out: assert property (@(posedge clk) disable iff (!rst_n)
      !en[1] |-> !irq_o[1]);
endmodule

// File: tb/sim_irq_src_frontend.sv
module sim_irq_src_frontend;
   localparam int N  = 40;
   localparam int AW = 12;
   localparam int IW = 6;

   logic          clk = 0, rst_n = 0;
   logic [N:1]    irq_in = '0;
   logic          bus_we = 0;
   logic [AW-1:0] bus_waddr = '0, bus_raddr = '0;
   logic [31:0]   bus_wdata = '0, bus_rdata;
   logic          claim_valid = 0;
   logic [IW-1:0] claim_id = '0;
   logic [N:0]    irq_o;

   int checks = 0, fails = 0;
   bit done = 0;
   logic [63:0] exp_ip = '0, exp_ie = '0;
   logic [63:0] valid_m;

   always #10ns clk = ~clk;

   irq_src_frontend #(.NUM_SRC(N), .SYNC_STAGES(2), .ADDR_W(AW), .IDW(IW)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
      .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_raddr(bus_raddr),
      .bus_rdata(bus_rdata), .claim_valid(claim_valid), .claim_id(claim_id),
      .irq_o(irq_o)
   );

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      bus_we = 1; bus_waddr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_we = 0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      bus_raddr = AW'(a);
      #1ns;
      d = bus_rdata;
   endtask

   task automatic claim(int id);
      @(negedge clk);
      claim_valid = 1; claim_id = IW'(id);
      @(negedge clk);
      claim_valid = 0;
   endtask

   task automatic state(string tag);
      logic [31:0] d;
      for (int k = 0; k < 2; k++) begin
         rd('h700 + k, d); chk({tag, " pend"}, 64'(d), 64'(exp_ip[k*32 +: 32]));
         rd('h780 + k, d); chk({tag, " en"},   64'(d), 64'(exp_ie[k*32 +: 32]));
      end
      chk({tag, " irq_o"}, 64'(irq_o), (exp_ip & exp_ie) & valid_m);
   endtask

   initial begin
      #(20ns * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      valid_m = ((64'd1 << (N + 1)) - 1) & ~64'd1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      state("R1 reset");
      rd(1, d); chk("R1 mode", 64'(d), 0);

      // R2 modes: every source to detached, read back
      for (int s = 1; s <= N; s++) wr(s, 32'd1);
      for (int s = 1; s <= N; s++) begin rd(s, d); chk("R2 cfg readback", 64'(d), 1); end
      wr(7, 32'd2); rd(7, d); chk("R2 reserved code", 64'(d), 0);
      wr(7, 32'd1);
      wr(6, 32'h406); rd(6, d); chk("R2 delegate bit", 64'(d), 6);
      wr(6, 32'd1);

      // R8 by-number sweep
      for (int s = 1; s <= N; s++) begin
         wr('h737, s); wr('h7B7, s);
         exp_ip[s] = 1; exp_ie[s] = 1;
         chk("R8 set by number", 64'(irq_o), exp_ip & exp_ie & valid_m);
      end
      state("R8 after set");
      for (int s = 1; s <= N; s++) begin wr('h777, s); wr('h7F7, s); end
      exp_ip = '0; exp_ie = '0;
      state("R8 after clear");
      wr('h737, 0); wr('h737, N + 1); wr('h7B7, N + 1); wr('h7B7, 0);
      state("R8 out of range");

      // R9 bit arrays across two words
      wr('h780, 32'hFFFF_FFFF); wr('h781, 32'hFFFF_FFFF);
      exp_ie = valid_m;
      wr('h700, 32'hA5A5_A5A5); wr('h701, 32'hFFFF_FFFF);
      exp_ip = {32'hFFFF_FFFF, 32'hA5A5_A5A5} & valid_m;
      state("R9 set arrays");
      wr('h740, 32'h0F0F_0F0F); wr('h741, 32'h0000_0003);
      exp_ip = exp_ip & ~{32'h0000_0003, 32'h0F0F_0F0F};
      state("R9 clear arrays");
      rd('h740, d); chk("R9 clear array reads 0", 64'(d), 0);
      wr('h740, 32'hFFFF_FFFF); wr('h741, 32'hFFFF_FFFF);
      exp_ip = '0;
      state("R9 clear all");

      // R7 detached ignores the line
      irq_in = '1; repeat (4) @(negedge clk);
      state("R7 line high");
      irq_in = '0; repeat (4) @(negedge clk);
      state("R7 line low");

      // R3 rising, R11 claim
      wr(1, 32'd4);
      @(negedge clk); irq_in[1] = 1; repeat (2) @(negedge clk);
      chk("R3 not before latency", 64'(irq_o[1]), 0);
      @(negedge clk);
      exp_ip[1] = 1; state("R3 rise sets");
      irq_in[1] = 0; repeat (3) @(negedge clk);
      state("R3 sticky");
      claim(1); exp_ip[1] = 0; state("R11 claim clears edge");
      irq_in[1] = 1; repeat (3) @(negedge clk);
      exp_ip[1] = 1; state("R3 second rise");
      wr('h777, 1); exp_ip[1] = 0; state("R3 sw clear");
      wr('h737, 1); exp_ip[1] = 1; state("R10 pre");
      wr(1, 32'd4); exp_ip[1] = 0; state("R10 cfg write clears");

      // R4 falling
      wr(2, 32'd5);
      irq_in[2] = 1; repeat (3) @(negedge clk);
      state("R4 rise ignored");
      irq_in[2] = 0; repeat (3) @(negedge clk);
      exp_ip[2] = 1; state("R4 fall sets");

      // R5 level high / low
      wr(3, 32'd6);
      irq_in[3] = 1; repeat (3) @(negedge clk);
      exp_ip[3] = 1; state("R5 high follows");
      wr('h777, 3); state("R5 sw clear ignored");
      claim(3); state("R11 claim ignored in level");
      wr('h7F7, 3); exp_ie[3] = 0; state("R12 masked");
      irq_in[3] = 0; repeat (3) @(negedge clk);
      exp_ip[3] = 0; state("R5 high drops");
      wr('h737, 3); state("R5 sw set ignored");
      wr(4, 32'd7); @(negedge clk);
      exp_ip[4] = 1; state("R5 low mode");
      irq_in[4] = 1; repeat (3) @(negedge clk);
      exp_ip[4] = 0; state("R5 low drops");

      // R6 off mode
      wr('h737, 5); exp_ip[5] = 1; state("R6 pre");
      wr(5, 32'd0); exp_ip[5] = 0; exp_ie[5] = 0; state("R6 off clears");
      wr('h737, 5); wr('h7B7, 5); state("R6 writes ignored");
      rd(5, d); chk("R6 mode off", 64'(d), 0);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule